// File: doc/BRIEF.md
# Two-Wire Slave Register Bank for Regulator Control

This block is a slave-only two-wire serial port with a small register bank attached. A host on the bus uses it to switch four voltage regulators on and off and to choose each regulator's output level. The bus lines SCL and SDA are oversampled by a much faster system clock. SDA is driven through an open-drain enable: when `sda_oe` is high the pad pulls the line low, and otherwise the line floats high through its pull-up.

Each access carries exactly one data byte. A write is START, the device address with W, a register pointer and one data byte, then STOP. A read sends the device address with W and the pointer, then a repeated START, the device address with R, and one byte returned by the slave. The master answers that byte with NACK and then STOP. The pointer never advances. Only three register addresses are mapped. Any other address reads as 0xFF and ignores writes.

Top module: `ldo_ctrl_i2c`

## Requirements
- R1: After reset `rail_en` is 4'b1111 and `rail1_sel`, `rail2_sel`, `rail3_sel` and `rail4_sel` are all zero.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After a STOP the block leaves SDA released and waits for the next START.
- R3: The block acknowledges the 7-bit device address 7'b1001000 (R/W bit: 0 = write, 1 = read). Any other address gets no acknowledge, and SDA stays released for the rest of that transfer until the next START.
- R4: The block acknowledges the pointer byte and the written data byte. Register 0x00 bits 3:0 drive `rail_en[3:0]`, with bit n enabling regulator n+1.
- R5: Register 0x08: bit 3 drives `rail1_sel` (0 = 2.75 V, 1 = 1.8 V), bit 2 drives `rail2_sel` (0 = 1.8 V, 1 = 1.5 V), and bits 1:0 drive `rail3_sel` (00 = 1.8 V, 01 = 1.5 V, 10 = 1.23 V, 11 = 1.8 V).
- R6: Register 0x0A bits 3:2 drive `rail4_sel` (00 = 1.8 V, 01 = 1.5 V, 10 or 11 = 1.2 V). Bits 1:0 of that register are not stored.
- R7: A read through a repeated START returns the addressed register MSB first. Bits that are not stored read as 0.
- R8: A read of any address other than 0x00, 0x08 or 0x0A returns 0xFF. A write to such an address changes no output.
- R9: Only one data byte is taken per write. A second data byte in the same transfer is not acknowledged and is not stored.
- R10: `sda_oe` only rises while SCL is low. A written value reaches the outputs while SCL is low, right after the data byte's eighth bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release it |
| rail_en | output | 4 | Enable for regulators 1 to 4 |
| rail1_sel | output | 1 | Regulator 1 level select |
| rail2_sel | output | 1 | Regulator 2 level select |
| rail3_sel | output | 2 | Regulator 3 level select |
| rail4_sel | output | 2 | Regulator 4 level select |

## Verification
A wrong bit counter or a wrong protocol state shows up at the ports within one byte. It appears either as an acknowledge in the wrong bit slot, which the master samples during the ninth SCL high phase, or as a regulator field that changes while no data byte is being accepted. The bench's reference model tracks the expected register contents and compares all regulator outputs on every clock. A write that lands in the wrong register or bit position is therefore caught within a few cycles of the SCL falling edge that commits it, not only at read-back. A corrupted read path is found by read-back of each mapped address and of unmapped ones.

// File: rtl/ldo_ctrl_pkg.sv
// Shared constants and types for the regulator control port.
package ldo_ctrl_pkg;
    localparam logic [6:0] DEV_ADDR   = 7'b1001000;
    localparam logic [7:0] REG_ENABLE = 8'h00;
    localparam logic [7:0] REG_SEL_A  = 8'h08;
    localparam logic [7:0] REG_SEL_B  = 8'h0A;
    localparam int         BYTE_W     = 8;
    localparam int         NUM_RAILS  = 4;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK,
        ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_SKIP
    } bus_state_t;
endpackage

// File: rtl/ldo_i2c_sync.sv
// Line conditioner: brings SCL and SDA into the clock domain through a
// flip-flop chain and derives SCL edges and START/STOP events.
// Assumes the system clock is at least 8x the bus bit rate.
module ldo_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // Shift the pad value through the synchroniser chain; idle bus is high.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    // Hold the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= synced;
    end

    assign scl_s     = synced[0];
    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] & prev[0];
    assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];
endmodule

// File: rtl/ldo_i2c_engine.sv
// Protocol engine: address match, pointer capture, single-byte write or
// read, acknowledge generation. One data byte per access, no increment.
// Assumes conditioned line events from ldo_i2c_sync.
module ldo_i2c_engine
    import ldo_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] ptr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    bus_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txd;
    logic              full;
    logic              rw;
    logic              rx_state;

    assign rx_state = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WDATA);

    // Advance the transfer state on bus events and drive the open-drain enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            txd     <= '0;
            full    <= 1'b0;
            rw      <= 1'b0;
            sda_oe  <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                full   <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                full   <= 1'b0;
                sda_oe <= 1'b0;
            end else if (rx_state) begin
                if (scl_rise && !full) begin
                    shreg <= {shreg[BYTE_W-2:0], sda_s};
                    cnt   <= cnt + 1'b1;
                    if (cnt == LAST_BIT) full <= 1'b1;
                end else if (scl_fall && full) begin
                    full <= 1'b0;
                    cnt  <= '0;
                    if (state == ST_ADDR) begin
                        if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                            sda_oe <= 1'b1;
                            rw     <= shreg[0];
                            state  <= ST_ADDR_ACK;
                        end else begin
                            state  <= ST_SKIP;
                        end
                    end else if (state == ST_PTR) begin
                        ptr    <= shreg;
                        sda_oe <= 1'b1;
                        state  <= ST_PTR_ACK;
                    end else begin
                        wr_en   <= 1'b1;
                        wr_data <= shreg;
                        sda_oe  <= 1'b1;
                        state   <= ST_WDATA_ACK;
                    end
                end
            end else if (scl_fall) begin
                case (state)
                    ST_ADDR_ACK: begin
                        cnt <= '0;
                        if (rw) begin
                            txd    <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_PTR;
                        end
                    end
                    ST_PTR_ACK: begin
                        sda_oe <= 1'b0;
                        state  <= ST_WDATA;
                    end
                    ST_WDATA_ACK: begin
                        sda_oe <= 1'b0;
                        state  <= ST_SKIP;
                    end
                    ST_RDATA: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_BIT) begin
                            sda_oe <= 1'b0;
                            state  <= ST_SKIP;
                        end else begin
                            txd    <= {txd[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~txd[BYTE_W-2];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ldo_reg_bank.sv
// Sparse register bank: enable register and two level-select registers.
// Unmapped addresses read 0xFF and ignore writes; unused bits read 0.
module ldo_reg_bank
    import ldo_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [BYTE_W-1:0]    ptr,
    input  logic [BYTE_W-1:0]    wr_data,
    output logic [BYTE_W-1:0]    rd_data,
    output logic [NUM_RAILS-1:0] rail_en,
    output logic                 rail1_sel,
    output logic                 rail2_sel,
    output logic [1:0]           rail3_sel,
    output logic [1:0]           rail4_sel
);
    localparam int PAD = BYTE_W - NUM_RAILS;

    logic [3:0] sel_a;

    // Commit a written byte to the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rail_en   <= '1;
            sel_a     <= '0;
            rail4_sel <= '0;
        end else if (wr_en) begin
            case (ptr)
                REG_ENABLE: rail_en   <= wr_data[NUM_RAILS-1:0];
                REG_SEL_A:  sel_a     <= wr_data[3:0];
                REG_SEL_B:  rail4_sel <= wr_data[3:2];
                default: ;
            endcase
        end
    end

    assign rail1_sel = sel_a[3];
    assign rail2_sel = sel_a[2];
    assign rail3_sel = sel_a[1:0];

    // Select the read-back byte for the current pointer.
    always_comb begin
        case (ptr)
            REG_ENABLE: rd_data = {{PAD{1'b0}}, rail_en};
            REG_SEL_A:  rd_data = {4'b0000, sel_a};
            REG_SEL_B:  rd_data = {4'b0000, rail4_sel, 2'b00};
            default:    rd_data = '1;
        endcase
    end
endmodule

// File: rtl/ldo_ctrl_i2c.sv
// Top: two-wire slave port controlling four regulators' enables and levels.
// Assumes SDA is open drain (sda_oe = 1 pulls low) and clk >= 8x bit rate.
module ldo_ctrl_i2c
    import ldo_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe,
    output logic [NUM_RAILS-1:0] rail_en,
    output logic                 rail1_sel,
    output logic                 rail2_sel,
    output logic [1:0]           rail3_sel,
    output logic [1:0]           rail4_sel
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [BYTE_W-1:0] ptr, wr_data, rd_data;

    ldo_i2c_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    ldo_i2c_engine u_engine (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr), .wr_en(wr_en),
        .wr_data(wr_data)
    );

    ldo_reg_bank u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data),
        .rd_data(rd_data), .rail_en(rail_en), .rail1_sel(rail1_sel),
        .rail2_sel(rail2_sel), .rail3_sel(rail3_sel), .rail4_sel(rail4_sel)
    );

    logic unused_scl_s;
    assign unused_scl_s = scl_s;
endmodule

// File: rtl/ldo_ctrl_i2c_chk.sv
// Property checker for ldo_ctrl_i2c, attached with bind below.
module ldo_ctrl_i2c_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic [3:0] rail_en,
    input logic       rail1_sel,
    input logic       rail2_sel,
    input logic [1:0] rail3_sel,
    input logic [1:0] rail4_sel,
    input logic       start_det,
    input logic       stop_det
);
    logic [9:0] fields;
    assign fields = {rail_en, rail1_sel, rail2_sel, rail3_sel, rail4_sel};

    // R1
    reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (fields == {4'hF, 6'b0}));
    // R10
    oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);
    // R10
    commit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fields) |-> !scl_i);
    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_oe);
    // R2
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_det) |-> !sda_oe);
endmodule

bind ldo_ctrl_i2c ldo_ctrl_i2c_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .rail_en(rail_en), .rail1_sel(rail1_sel), .rail2_sel(rail2_sel),
    .rail3_sel(rail3_sel), .rail4_sel(rail4_sel),
    .start_det(start_det), .stop_det(stop_det)
);

// File: tb/ldo_ctrl_i2c_test.sv
// Bench: drives a bus master, keeps a behavioural register model and
// compares all regulator outputs against it on every clock.
module ldo_ctrl_i2c_test;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic [3:0] rail_en;
    logic rail1_sel, rail2_sel;
    logic [1:0] rail3_sel, rail4_sel;
    wire  sda_line = !(sda_oe || m_low);

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit hold = 1'b1;
    bit done = 1'b0;
    int m_en = 15, m_a = 0, m_b = 0;

    always #5 clk = ~clk;

    ldo_ctrl_i2c uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .rail_en(rail_en), .rail1_sel(rail1_sel),
        .rail2_sel(rail2_sel), .rail3_sel(rail3_sel), .rail4_sel(rail4_sel)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // R4 R5 R6 R8 R9: outputs follow the model on every clock
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !hold && !done) begin
            check(rail_en, m_en, "R4 rail_en vs model");
            check({rail1_sel, rail2_sel, rail3_sel}, m_a & 15, "R5 sel_a vs model");
            check(rail4_sel, (m_b >> 2) & 3, "R6 rail4_sel vs model");
        end
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wait_q(1);
        scl = 1'b1;   wait_q(1);
        m_low = 1'b1; wait_q(1);
        scl = 1'b0;   wait_q(1);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wait_q(1);
        scl = 1'b1;   wait_q(1);
        m_low = 1'b0; wait_q(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_low = !b[i]; wait_q(1);
            scl = 1'b1;    wait_q(2);
            scl = 1'b0;    wait_q(1);
        end
        m_low = 1'b0; wait_q(1);
        scl = 1'b1;   wait_q(1);
        acked = !sda_line;
        wait_q(1);
        scl = 1'b0;   wait_q(1);
    endtask

    task automatic recv_byte(output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wait_q(1); scl = 1'b1;
            wait_q(1); b[i] = sda_line;
            wait_q(1); scl = 1'b0;
        end
        wait_q(1);
        scl = 1'b1; wait_q(2);
        scl = 1'b0; wait_q(1);
    endtask

    function automatic int model_read(input int a);
        if (a == 8'h00) return m_en;
        if (a == 8'h08) return m_a & 15;
        if (a == 8'h0A) return m_b & 8'h0C;
        return 8'hFF;
    endfunction

    task automatic write_reg(input int a, input int d);
        bit k;
        bus_start();
        send_byte(8'h90, k); check(k, 1, "R3 address ack on write");
        send_byte(a[7:0], k); check(k, 1, "R4 pointer ack");
        hold = 1'b1;
        send_byte(d[7:0], k); check(k, 1, "R4 data ack");
        if (a == 8'h00) m_en = d & 15;
        else if (a == 8'h08) m_a = d & 15;
        else if (a == 8'h0A) m_b = d & 8'h0C;
        hold = 1'b0;
        bus_stop();
        check(sda_oe, 0, "R2 SDA released after STOP");
    endtask

    task automatic read_reg(input int a, input string tag);
        bit k;
        logic [7:0] v;
        bus_start();
        send_byte(8'h90, k); check(k, 1, "R3 address ack before read");
        send_byte(a[7:0], k); check(k, 1, "R4 pointer ack before read");
        bus_start();
        send_byte(8'h91, k); check(k, 1, "R3 read address ack");
        recv_byte(v);
        check(v, model_read(a), tag);
        bus_stop();
    endtask

    initial begin
        bit k;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check(rail_en, 4'hF, "R1 rail_en reset");
        check({rail1_sel, rail2_sel, rail3_sel, rail4_sel}, 0, "R1 selects reset");
        check(sda_oe, 0, "R1 SDA released at reset");
        hold = 1'b0;

        write_reg(8'h00, 8'h05);                 // R4
        read_reg(8'h00, "R7 enable read-back");
        write_reg(8'h08, 8'hFB);                 // R5
        read_reg(8'h08, "R7 sel_a read-back, upper bits zero");
        write_reg(8'h08, 8'h06);                 // R5 rail3 = 10
        write_reg(8'h0A, 8'hFF);                 // R6
        read_reg(8'h0A, "R6 sel_b read-back bits 1:0 zero");
        write_reg(8'h0A, 8'h04);                 // R6
        read_reg(8'h3C, "R8 unmapped read 0xFF");
        write_reg(8'h01, 8'h00);                 // R8 no output change
        read_reg(8'h01, "R8 unmapped after write 0xFF");

        // R3 wrong address: no ack, nothing stored
        bus_start();
        send_byte(8'h92, k); check(k, 0, "R3 mismatched address not acked");
        send_byte(8'h00, k); check(k, 0, "R3 pointer ignored after mismatch");
        send_byte(8'h00, k); check(k, 0, "R3 data ignored after mismatch");
        bus_stop();
        read_reg(8'h00, "R3 enable unchanged after mismatch");

        // R9 second data byte refused
        bus_start();
        send_byte(8'h90, k); check(k, 1, "R9 address ack");
        send_byte(8'h00, k); check(k, 1, "R9 pointer ack");
        hold = 1'b1;
        send_byte(8'h03, k); check(k, 1, "R9 first data ack");
        m_en = 3;
        hold = 1'b0;
        send_byte(8'h0C, k); check(k, 0, "R9 second data not acked");
        bus_stop();
        read_reg(8'h00, "R9 second byte not stored");

        wait_q(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule